// File: doc/BRIEF.md
# Double-Buffered Filter Coefficient Bank

This block stores the coefficients for a 32-tap multiply-accumulate filter in two banks. The active bank feeds the datapath through a wide coefficient output. The shadow bank can be loaded at any time without disturbing the computation in progress. A word-addressed synchronous register port gives access to both banks and to a one-bit exchange request. Writes take effect on the rising clock edge. Read data is combinational from the address and the read strobe.

The two banks trade contents in a single clock. All pairs move at once, so after an exchange the previous active values can be read back from the shadow bank. In manual mode software requests an exchange. The exchange waits until the datapath signals the end of the computation it is running, or happens on the next edge if the datapath is idle. In automatic mode the banks trade at every end-of-computation pulse, and software requests are discarded.

A size setting selects how many low bits of each stored 16-bit word form the two's-complement coefficient. The selected field is sign-extended to 16 bits before it reaches the datapath. Any bank access made while an exchange is outstanding is refused and recorded in a sticky fault flag.

Top module: `coef_bank_swap`

## Requirements
- R1: After reset, every coefficient output is 0, `access_fault` is 0, and a read of the control word (address 64) returns 0.
- R2: The shadow bank sits at addresses 0..31, with tap i at address i. A write there is accepted whether or not `dp_busy` is high, and it reads back unchanged.
- R3: The active bank sits at addresses 32..63, with tap i at address 32+i, and it can be read at any time. A write there is stored only while `dp_busy` is 0 and is dropped while `dp_busy` is 1.
- R4: Writing the control word at address 64 with bit 0 = 1 while `cfg_auto_swap` is 0 makes bit 0 of the control word read 1 (request pending). If `dp_busy` is 0, the exchange takes place at the next rising edge.
- R5: While `dp_busy` is 1, a pending exchange waits for the edge at which `dp_cycle_end` is 1. The request bit stays 1 until that edge and reads 0 after it.
- R6: When `cfg_auto_swap` is 1, the banks trade at every rising edge that samples `dp_cycle_end` = 1. A request write in this mode is ignored, so the control word keeps reading 0.
- R7: While a request is pending, or in the cycle in which an exchange executes, a read of either bank returns 0 and a write to either bank is dropped.
- R8: The coefficient for tap i appears on `coef_out[16*i+15:16*i]`. `cfg_coef_size` selects the width of the low field: 00 = 4 bits, 01 = 8, 10 = 12, 11 = 16. That field is sign-extended to 16 bits.
- R9: An exchange is a full trade: the active bank takes the shadow values, and the shadow bank takes the previous active values, for all taps in the same edge.
- R10: A bank access refused under R7 sets `access_fault` at the next edge, and the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| dp_busy | input | 1 | Datapath is computing |
| dp_cycle_end | input | 1 | Datapath finishes a computation at this edge |
| cfg_auto_swap | input | 1 | 1 = trade banks at every computation end |
| cfg_coef_size | input | 2 | Coefficient field width select |
| coef_out | output | 512 | Active-bank coefficients, sign-extended, tap i in slice i |
| access_fault | output | 1 | Sticky flag for refused bank accesses |

## Verification
The exchange is tried in three situations. With the datapath idle, it must happen at the very next edge. With the datapath busy, it must wait for the cycle-end pulse. In automatic mode, repeated pulses must flip the banks back and forth. Each shadow tap holds a distinct value and the active bank holds a different pattern, so a partial trade, a copy in only one direction, or an early trade shows up at both the outputs and the read port. The coefficient word 0x0A79 is presented in all four size codes: the 4-bit and 12-bit fields have a set sign bit and the 8-bit field does not, which tells correct extension apart from plain masking. Bank accesses made while a request is pending separate refused reads and writes from accepted ones.

// File: rtl/coef_bank_swap.sv
module coef_bank_swap #(
  parameter int NTAPS = 32,
  parameter int CW    = 16,
  parameter int AW    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [AW-1:0]         bus_addr,
  input  logic [CW-1:0]         bus_wdata,
  output logic [CW-1:0]         bus_rdata,
  input  logic                  dp_busy,
  input  logic                  dp_cycle_end,
  input  logic                  cfg_auto_swap,
  input  logic [1:0]            cfg_coef_size,
  output logic [NTAPS*CW-1:0]   coef_out,
  output logic                  access_fault
);
  localparam int IW = $clog2(NTAPS);
  localparam logic [AW-1:0] CUR_BASE = AW'(NTAPS);
  localparam logic [AW-1:0] CTRL     = AW'(2*NTAPS);

  logic [CW-1:0] upd [NTAPS];
  logic [CW-1:0] cur [NTAPS];
  logic          pend;

  wire is_upd   = bus_addr < CUR_BASE;
  wire is_cur   = (bus_addr >= CUR_BASE) && (bus_addr < CTRL);
  wire is_ctrl  = bus_addr == CTRL;
  wire [IW-1:0] idx = IW'(is_cur ? bus_addr - CUR_BASE : bus_addr);

  wire swap_now = (pend && (!dp_busy || dp_cycle_end)) || (cfg_auto_swap && dp_cycle_end);
  wire blocked  = pend || swap_now;
  wire bank_acc = (bus_rd || bus_wr) && (is_upd || is_cur);
  wire req_wr   = bus_wr && is_ctrl && bus_wdata[0] && !cfg_auto_swap;

  function automatic logic [CW-1:0] sext(input logic [CW-1:0] v, input logic [1:0] sz);
    int sh;
    logic signed [CW-1:0] t;
    sh = CW - (int'(sz) + 1) * (CW / 4);
    t  = $signed(v << sh);
    return t >>> sh;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) begin
        upd[i] <= '0;
        cur[i] <= '0;
      end
      pend         <= 1'b0;
      access_fault <= 1'b0;
    end else begin
      if (swap_now) begin
        for (int i = 0; i < NTAPS; i++) begin
          upd[i] <= cur[i];
          cur[i] <= upd[i];
        end
      end else if (bus_wr && !blocked) begin
        if (is_upd)
          upd[idx] <= bus_wdata;
        else if (is_cur && !dp_busy)
          cur[idx] <= bus_wdata;
      end
      if (swap_now)
        pend <= 1'b0;
      else if (req_wr)
        pend <= 1'b1;
      if (bank_acc && blocked)
        access_fault <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (is_upd && !blocked)
        bus_rdata = upd[idx];
      else if (is_cur && !blocked)
        bus_rdata = cur[idx];
      else if (is_ctrl)
        bus_rdata = {{(CW-1){1'b0}}, pend};
    end
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign coef_out[g*CW +: CW] = sext(cur[g], cfg_coef_size);
  end
endmodule

// File: rtl/coef_bank_swap_chk.sv
module coef_bank_swap_chk #(
  parameter int NTAPS = 32,
  parameter int CW    = 16,
  parameter int AW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dp_busy,
  input logic          dp_cycle_end,
  input logic          cfg_auto_swap,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [CW-1:0] bus_wdata,
  input logic [CW-1:0] bus_rdata,
  input logic          pend,
  input logic          fault,
  input logic [CW-1:0] cur0,
  input logic [CW-1:0] upd0
);
  localparam logic [AW-1:0] CUR_BASE = AW'(NTAPS);
  localparam logic [AW-1:0] CTRL     = AW'(2*NTAPS);

  wire fire = (pend && (!dp_busy || dp_cycle_end)) || (cfg_auto_swap && dp_cycle_end);

  AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && !fire && !pend) |=> upd0 == $past(bus_wdata)); // R2
  AST_ACTIVE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_busy && !fire && bus_wr && bus_addr == CUR_BASE) |=> cur0 == $past(cur0)); // R3
  AST_IDLE_SWAP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !dp_busy) |=> !pend); // R4
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && dp_busy && !dp_cycle_end) |=> pend); // R5
  AST_AUTO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_swap && !pend) |=> !pend); // R6
  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && bus_rd && bus_addr < CTRL) |-> bus_rdata == '0); // R7
  AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cur0 == $past(upd0) && upd0 == $past(cur0))); // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R10
endmodule

bind coef_bank_swap coef_bank_swap_chk #(.NTAPS(NTAPS), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dp_busy(dp_busy), .dp_cycle_end(dp_cycle_end),
  .cfg_auto_swap(cfg_auto_swap), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pend(pend), .fault(access_fault), .cur0(cur[0]), .upd0(upd[0])
);

// File: tb/coef_bank_swap_tb.sv
`timescale 1ns/100ps
module coef_bank_swap_tb;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [6:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic dp_busy = 0, dp_cycle_end = 0, cfg_auto_swap = 0;
  logic [1:0] cfg_coef_size = 2'b11;
  logic [N*16-1:0] coef_out;
  logic access_fault;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  coef_bank_swap u_dut (.*);

  function automatic logic [15:0] upat(int i);
    return 16'(16'h0101 + i * 16'h0123);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #0.5 bus_wr = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #0.5 d = bus_rdata; bus_rd = 0;
  endtask

  function automatic logic [15:0] tap(int i);
    return coef_out[i*16 +: 16];
  endfunction

  task automatic t_reset;
    logic [15:0] d;
    rd(7'd64, d);
    chk("R1 ctrl", d, 0);
    chk("R1 fault", access_fault, 0);
    for (int i = 0; i < N; i++) if (tap(i) !== 0) chk("R1 coef", tap(i), 0);
    chk("R1 coef0", tap(0), 0);
  endtask

  task automatic t_shadow;
    logic [15:0] d;
    dp_busy = 1;
    for (int i = 0; i < N; i++) wr(7'(i), upat(i));
    dp_busy = 0;
    rd(7'd0, d);  chk("R2 tap0", d, upat(0));
    rd(7'd31, d); chk("R2 tap31", d, upat(31));
    chk("R2 active untouched", tap(3), 0);
  endtask

  task automatic t_active;
    logic [15:0] d;
    wr(7'd37, 16'h0A79);
    rd(7'd37, d); chk("R3 idle write", d, 16'h0A79);
    dp_busy = 1;
    wr(7'd37, 16'h1234);
    rd(7'd37, d); chk("R3 busy write dropped", d, 16'h0A79);
    dp_busy = 0;
  endtask

  task automatic t_size;
    cfg_coef_size = 2'b00; #1 chk("R8 4-bit", tap(5), 16'hFFF9);
    cfg_coef_size = 2'b01; #1 chk("R8 8-bit", tap(5), 16'h0079);
    cfg_coef_size = 2'b10; #1 chk("R8 12-bit", tap(5), 16'hFA79);
    cfg_coef_size = 2'b11; #1 chk("R8 16-bit", tap(5), 16'h0A79);
  endtask

  task automatic t_idle_swap;
    logic [15:0] d;
    wr(7'd64, 16'h0001);
    rd(7'd64, d); chk("R4 pending", d, 1);
    rd(7'd64, d); chk("R4 cleared after swap", d, 0);
    chk("R9 active tap0", tap(0), upat(0));
    chk("R9 active tap31", tap(31), upat(31));
    rd(7'd5, d); chk("R9 shadow has old active", d, 16'h0A79);
    rd(7'd6, d); chk("R9 shadow tap6", d, 0);
  endtask

  task automatic t_deferred;
    logic [15:0] d;
    dp_busy = 1;
    wr(7'd64, 16'h0001);
    rd(7'd1, d); chk("R7 blocked read", d, 0);
    wr(7'd1, 16'hBEEF);
    repeat (3) @(posedge clk);
    rd(7'd64, d); chk("R5 still pending", d, 1);
    chk("R5 no early swap", tap(2), upat(2));
    chk("R10 fault set", access_fault, 1);
    @(negedge clk); dp_cycle_end = 1;
    @(posedge clk); #0.5 dp_cycle_end = 0; dp_busy = 0;
    rd(7'd64, d); chk("R5 cleared at cycle end", d, 0);
    chk("R5 swapped back tap5", tap(5), 16'h0A79);
    chk("R7 write dropped", tap(1), 0);
    rd(7'd1, d); chk("R9 shadow tap1", d, upat(1));
    chk("R10 fault sticky", access_fault, 1);
  endtask

  task automatic t_auto;
    logic [15:0] d;
    cfg_auto_swap = 1; dp_busy = 1;
    wr(7'd64, 16'h0001);
    rd(7'd64, d); chk("R6 request ignored", d, 0);
    chk("R6 no swap without end", tap(5), 16'h0A79);
    @(negedge clk); dp_cycle_end = 1;
    @(posedge clk); #0.5 dp_cycle_end = 0;
    @(negedge clk); chk("R6 first auto swap", tap(5), upat(5));
    dp_cycle_end = 1;
    @(posedge clk); #0.5 dp_cycle_end = 0;
    @(negedge clk); chk("R6 second auto swap", tap(5), 16'h0A79);
    cfg_auto_swap = 0; dp_busy = 0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    t_reset;
    t_shadow;
    t_active;
    t_size;
    t_idle_swap;
    t_deferred;
    t_auto;
    @(negedge clk); rst_n = 0;
    #1 chk("R10 fault cleared by reset", access_fault, 0);
    done = 1;
    finish_up;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_up;
    end
  end
endmodule